// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked byte-shifting mode of a small microcontroller serial port. One pin carries the shift clock that the block generates. The other pin is a bidirectional data line. A transfer begins with one of two commands. The transmit command loads a byte and shifts it out. The receive command shifts eight bits in from the line. When the eighth bit is done, the block pulses a completion flag. A received byte is then held in a data register until the next receive finishes.

A 16-bit divider setting fixes the shift clock rate. Its top bit must be set for the internal oscillator to drive the transfer. Its low 15 bits, N, set the length of the low phase of each clock period. The smallest setting gives a period of four oscillator cycles, and each step up in N adds two cycles. The clock idles high. During the low phase the outgoing bit changes, and on the rising edge the incoming bit is sampled.

The controller is a three-state machine:
- ST_IDLE: waits for a command. With the divider enabled, a command moves it to ST_LOW.
- ST_LOW: the clock is low. When the low phase ends, the machine moves to ST_HIGH and takes in a receive bit.
- ST_HIGH: the clock is high. When the high phase ends, the machine returns to ST_LOW after bits 0 to 6. After bit 7 it goes to ST_IDLE and raises the completion pulse.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk_o is 1, data_oe is 0, busy is 0, done is 0 and rx_data is 0. Whenever busy is 0, sclk_o is 1.
- R2: A command is accepted only while busy is 0 and baud[15] is 1. If start_tx and start_rx are both high in the same cycle, the transmit command wins.
- R3: Let N be baud[14:0], with 0 treated as 1. Each clock period has a low phase of 2*N cycles and a high phase of 2 cycles. So 8001h gives a period of 4 cycles with 2 low, and 8002h gives a period of 6 cycles with 4 low.
- R4: A transmit sends tx_byte least significant bit first. data_o carries bit k at the k-th rising edge of sclk_o and only changes while sclk_o is low.
- R5: A receive samples data_i at each rising edge of sclk_o, with the first sample landing in bit 0. rx_data is updated only when a receive completes, and a transmit leaves it unchanged.
- R6: busy stays high for exactly 8*(2*N+2) cycles after the accepting edge. done is a one-cycle pulse in the first cycle with busy low.
- R7: data_oe is high for the whole of a transmit and low during a receive and while idle. The line is released 2 cycles after the last rising edge of sclk_o.
- R8: start_tx, start_rx and tx_byte are ignored while busy is high. The transfer in progress keeps its data and its length.
- R9: While baud[15] is 0, start commands are ignored and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud | input | 16 | Bit 15 enables the internal source. Bits 14:0 are the divider N |
| start_tx | input | 1 | Command: transmit tx_byte |
| start_rx | input | 1 | Command: receive a byte |
| tx_byte | input | 8 | Byte to transmit, loaded on the accepting edge |
| data_i | input | 1 | Data line input |
| sclk_o | output | 1 | Shift clock, idles high |
| data_o | output | 1 | Data line output value |
| data_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received byte |

## Verification
Two functions can fall in the same cycle. One is the completion pulse of a finished transfer. The other is the acceptance of a new command, since the machine is already idle when done is high. The bench issues the next command in exactly the cycle where done is seen. It then checks that the second transfer runs at full length with correct data. A second pair also shares a cycle: a fresh command and a transfer still in flight. The bench drives both commands together with a changed byte mid-transfer, and checks that neither the shifted data nor the busy length changes.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssr_state_e;
endpackage

// File: rtl/ssr_phase_timer.sv
module ssr_phase_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: phase length comes from a steady down count
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_out,
    input  logic         shift_in,
    input  logic         in_bit,
    input  logic         capture,
    output logic         lsb,
    output logic [W-1:0] rx_data
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                sr_q <= load_val;
            end else if (shift_in) begin
                sr_q <= {in_bit, sr_q[W-1:1]};
            end else if (shift_out) begin
                sr_q <= {1'b0, sr_q[W-1:1]};
            end
            if (capture) begin
                rx_data <= sr_q;
            end
        end
    end

    assign lsb = sr_q[0];

    // R5: received byte holds between completions
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rx_data));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssr_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] baud,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [DW-1:0] tx_byte,
    input  logic          data_i,
    output logic          sclk_o,
    output logic          data_o,
    output logic          data_oe,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int BITW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BITW-1:0] LAST_BIT = BITW'(DW - 1);
    localparam logic [BW-1:0]   HIGH_LOAD = BW'(1);

    ssr_state_e state_q, state_d;
    logic [BITW-1:0] bit_q;
    logic            mode_tx_q;
    logic            done_q;

    logic [BW-2:0] div_n;
    logic [BW-2:0] low_n;
    logic [BW-1:0] low_load;
    logic          src_en;
    logic          accept;

    logic          tmr_load;
    logic [BW-1:0] tmr_val;
    logic          tmr_exp;
    logic          sh_load, sh_out, sh_in, sh_cap;
    logic          bit_inc, done_d;
    logic          sr_lsb;

    assign div_n    = baud[BW-2:0];
    assign low_n    = (div_n == '0) ? (BW-1)'(1) : div_n;
    assign low_load = {low_n, 1'b0} - 1'b1;
    assign src_en   = baud[BW-1];
    assign accept   = (state_q == ST_IDLE) && src_en && (start_tx || start_rx);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = low_load;
        sh_load  = 1'b0;
        sh_out   = 1'b0;
        sh_in    = 1'b0;
        sh_cap   = 1'b0;
        bit_inc  = 1'b0;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    sh_load  = start_tx;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HIGH_LOAD;
                    sh_in    = !mode_tx_q;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    if (bit_q == LAST_BIT) begin
                        state_d = ST_IDLE;
                        sh_cap  = !mode_tx_q;
                        done_d  = 1'b1;
                    end else begin
                        state_d  = ST_LOW;
                        tmr_load = 1'b1;
                        sh_out   = mode_tx_q;
                        bit_inc  = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_q     <= '0;
            mode_tx_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (accept) begin
                bit_q     <= '0;
                mode_tx_q <= start_tx;
            end else if (bit_inc) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        sclk_o  = (state_q != ST_LOW);
        busy    = (state_q != ST_IDLE);
        data_oe = busy && mode_tx_q;
        data_o  = sr_lsb;
        done    = done_q;
    end

    ssr_phase_timer #(.CW(BW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    ssr_shifter #(.W(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (tx_byte),
        .shift_out (sh_out),
        .shift_in  (sh_in),
        .in_bit    (data_i),
        .capture   (sh_cap),
        .lsb       (sr_lsb),
        .rx_data   (rx_data)
    );

    // R1: clock idles high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o);
    // R4: outgoing bit steady while clock stays high
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && data_oe && sclk_o && $past(sclk_o)) |-> $stable(data_o));
    // R6: single-cycle completion, only when idle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: line released when idle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !data_oe);
    // R8: direction fixed for the whole transfer
    a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_oe));
    // R9: disabled source blocks every command
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !baud[BW-1]) |=> !busy);
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud = 16'h8001;
    logic        start_tx = 1'b0;
    logic        start_rx = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic        data_i = 1'b1;
    logic        sclk_o, data_o, data_oe, busy, done;
    logic [7:0]  rx_data;

    int n_cmp = 0;
    int n_err = 0;
    int cyc_total = 0;

    always #10 clk = ~clk;

    sync_shift_port dut_i (
        .clk(clk), .rst_n(rst_n), .baud(baud), .start_tx(start_tx),
        .start_rx(start_rx), .tx_byte(tx_byte), .data_i(data_i),
        .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe),
        .busy(busy), .done(done), .rx_data(rx_data)
    );

    // {baud, is_tx, byte}
    localparam logic [24:0] VEC [0:5] = '{
        {16'h8001, 1'b1, 8'hA5},
        {16'h8001, 1'b0, 8'h3C},
        {16'h8002, 1'b1, 8'h81},
        {16'h8002, 1'b0, 8'hE7},
        {16'h8005, 1'b1, 8'h5A},
        {16'h8000, 1'b0, 8'h96}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int div_of(input logic [15:0] b);
        return (b[14:0] == 0) ? 1 : int'(b[14:0]);
    endfunction

    task automatic run_xfer(input logic [15:0] b, input bit tx, input bit both,
                            input bit disturb, input logic [7:0] by,
                            output logic [7:0] cap, output int cyc,
                            output int lowfirst, output bit oe_ok, output bit done_ok);
        int  rises;
        int  lowrun;
        bit  prev;
        baud     = b;
        tx_byte  = by;
        start_tx = tx | both;
        start_rx = !tx | both;
        data_i   = by[0];
        @(negedge clk);
        start_tx = 1'b0;
        start_rx = 1'b0;
        cap = 8'h00; cyc = 0; lowfirst = 0; oe_ok = 1'b1;
        rises = 0; lowrun = 0; prev = 1'b1;
        while (busy && cyc < 5000) begin
            if (disturb && cyc == 5) begin
                start_tx = 1'b1; start_rx = 1'b1; tx_byte = ~by;
            end else if (disturb && cyc == 6) begin
                start_tx = 1'b0; start_rx = 1'b0; tx_byte = by;
            end
            if (!sclk_o) lowrun++;
            if (!prev && sclk_o) begin
                if (rises == 0) lowfirst = lowrun;
                if (tx && rises < 8) cap[rises[2:0]] = data_o;
                rises++;
                lowrun = 0;
            end
            if (rises < 8) data_i = by[rises[2:0]];
            if (data_oe !== (tx | both)) oe_ok = 1'b0;
            prev = sclk_o;
            cyc++;
            @(negedge clk);
        end
        if (data_oe !== 1'b0) oe_ok = 1'b0;
        done_ok = (done === 1'b1);
        if (!(tx | both)) cap = rx_data;
    endtask

    initial begin
        while (cyc_total < 100000) begin
            @(posedge clk);
            cyc_total++;
        end
        n_cmp++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        logic [7:0] cap;
        logic [7:0] last_rx;
        int cyc, lowf, n;
        bit oe_ok, done_ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk_o === 1'b1 && busy === 1'b0 && done === 1'b0 && data_oe === 1'b0,
            "R1 reset outputs", {sclk_o, busy, done, data_oe}, 4'b1000);
        chk(rx_data === 8'h00, "R1 reset rx_data", rx_data, 0);
        last_rx = 8'h00;

        for (int i = 0; i < 6; i++) begin
            logic [15:0] vb;
            bit vt;
            logic [7:0] vy;
            {vb, vt, vy} = VEC[i];
            n = div_of(vb);
            run_xfer(vb, vt, 1'b0, 1'b0, vy, cap, cyc, lowf, oe_ok, done_ok);
            chk(cap === vy, vt ? "R4 tx byte" : "R5 rx byte", cap, vy);
            chk(cyc == 8 * (2 * n + 2), "R6 busy length", cyc, 8 * (2 * n + 2));
            chk(lowf == 2 * n, "R3 low phase", lowf, 2 * n);
            chk(oe_ok && done_ok, "R7 oe and R6 done", {oe_ok, done_ok}, 2'b11);
            if (!vt) last_rx = vy;
            else chk(rx_data === last_rx, "R5 rx hold on tx", rx_data, last_rx);
            @(negedge clk);
            chk(done === 1'b0, "R6 done one cycle", done, 0);
        end

        // R2: both commands together -> transmit
        run_xfer(16'h8001, 1'b1, 1'b1, 1'b0, 8'hC3, cap, cyc, lowf, oe_ok, done_ok);
        chk(cap === 8'hC3 && oe_ok, "R2 tx priority", cap, 8'hC3);
        chk(rx_data === last_rx, "R2 rx untouched", rx_data, last_rx);
        @(negedge clk);

        // R8: commands and byte change mid-transfer are ignored
        run_xfer(16'h8002, 1'b1, 1'b0, 1'b1, 8'h69, cap, cyc, lowf, oe_ok, done_ok);
        chk(cap === 8'h69, "R8 data unchanged", cap, 8'h69);
        chk(cyc == 48, "R8 length unchanged", cyc, 48);

        // completion and new command in the same cycle
        run_xfer(16'h8003, 1'b0, 1'b0, 1'b0, 8'h4B, cap, cyc, lowf, oe_ok, done_ok);
        chk(done_ok && cap === 8'h4B, "R6 first of back-to-back", cap, 8'h4B);
        run_xfer(16'h8003, 1'b1, 1'b0, 1'b0, 8'hD2, cap, cyc, lowf, oe_ok, done_ok);
        chk(cap === 8'hD2 && cyc == 64, "R2 start in done cycle", cyc, 64);
        chk(rx_data === 8'h4B, "R5 rx held after tx", rx_data, 8'h4B);
        @(negedge clk);

        // R9: disabled source
        baud = 16'h0005;
        start_tx = 1'b1;
        start_rx = 1'b1;
        @(negedge clk);
        start_tx = 1'b0;
        start_rx = 1'b0;
        chk(busy === 1'b0 && sclk_o === 1'b1, "R9 ignored when disabled", busy, 0);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && data_oe === 1'b0, "R9 stays idle", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule